// File: doc/BRIEF.md
# Programmable sum-of-products plane

This block is the combinational core of a configurable logic array. It has a bank of array inputs, and each input is offered to every product term in both true and inverted form. Each product term is a wide AND gate. A static connection mask chooses which literals the gate sees. Fixed OR sums of unequal width then combine the product terms, one sum for each output.

Beside the logic terms, every output owns four control terms: output enable, clock or latch enable, asynchronous preset and asynchronous reset. These are evaluated but not consumed here. Two global terms, one for preload and one for observation, complete the set.

With the default parameters the plane has 29 array inputs and 16 outputs. It holds 112 logic terms, 64 per-output control terms and 2 global terms, 178 terms in all. The inputs are typically fed by dedicated input pins, by the feedback paths of the output cells and by a shared enable pin. The plane treats all of them alike. Storage elements, pin drivers and the loading of the masks sit outside the block.

Top module: `sop_plane`

## Requirements
- R1: Literal 2i of a term is array input i in true form, and literal 2i+1 is its complement. A mask bit of 1 connects that literal to the term.
- R2: A product term whose mask is all zero evaluates to 1.
- R3: A product term whose mask connects both literals of the same input evaluates to 0, whatever the input values.
- R4: In all other cases a product term is the AND of its connected literals, evaluated from the present inputs with no clock.
- R5: Logic terms are indexed from 0 upward, and each output's terms follow those of the output before it. Outputs 0 to 7 each OR 4 terms, outputs 8 to 11 each OR 8 terms, and outputs 12 to 15 each OR 12 terms. A term drives only the sum of the output that owns it.
- R6: Each output's enable, clock, preset and reset terms come from masks of their own. They follow R1 to R4 and do not depend on the logic masks.
- R7: The global preload and observe terms each come from a single mask of their own and follow R1 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| arr_in | input | 29 | Array inputs |
| logic_mask | input | 112 x 58 | Connection mask for each logic term |
| oe_mask | input | 16 x 58 | Connection mask for each output-enable term |
| ck_mask | input | 16 x 58 | Connection mask for each clock/latch-enable term |
| set_mask | input | 16 x 58 | Connection mask for each preset term |
| clr_mask | input | 16 x 58 | Connection mask for each reset term |
| pload_mask | input | 58 | Connection mask for the global preload term |
| obs_mask | input | 58 | Connection mask for the global observe term |
| sum_out | output | 16 | OR sum for each output |
| oe_term | output | 16 | Output-enable term for each output |
| ck_term | output | 16 | Clock/latch-enable term for each output |
| set_term | output | 16 | Preset term for each output |
| clr_term | output | 16 | Reset term for each output |
| pload_term | output | 1 | Global preload term |
| obs_term | output | 1 | Global observe term |

## Verification
The plane holds no state, so any fault in a term or a group boundary shows on the outputs as soon as the inputs settle. It does not wait for a clock edge. If a group boundary is off by one, a single enabled logic term lights the wrong sum bit, so the bench opens each of the 112 terms in turn. If literal polarity is swapped, a term connected to a single literal follows the wrong value of that input. A sweep of all 58 literals through the preload term exposes this. Random sparse masks then compare every term class against a model computed in the bench.

// File: rtl/sop_pkg.sv
package sop_pkg;

  localparam int unsigned DEF_N_IN     = 29;
  localparam int unsigned DEF_N_OUT    = 16;
  localparam int unsigned DEF_N_SMALL  = 8;
  localparam int unsigned DEF_SZ_SMALL = 4;
  localparam int unsigned DEF_N_MID    = 4;
  localparam int unsigned DEF_SZ_MID   = 8;
  localparam int unsigned DEF_SZ_BIG   = 12;

  // number of logic terms feeding the sum of output k
  function automatic int unsigned grp_size(input int unsigned k,
                                           input int unsigned n_small,
                                           input int unsigned sz_small,
                                           input int unsigned n_mid,
                                           input int unsigned sz_mid,
                                           input int unsigned sz_big);
    if (k < n_small) return sz_small;
    else if (k < n_small + n_mid) return sz_mid;
    else return sz_big;
  endfunction

  // index of the first logic term of output k
  function automatic int unsigned grp_base(input int unsigned k,
                                           input int unsigned n_small,
                                           input int unsigned sz_small,
                                           input int unsigned n_mid,
                                           input int unsigned sz_mid,
                                           input int unsigned sz_big);
    int unsigned acc;
    acc = 0;
    for (int unsigned j = 0; j < k; j++)
      acc += grp_size(j, n_small, sz_small, n_mid, sz_mid, sz_big);
    return acc;
  endfunction

endpackage

// File: rtl/sop_pterm.sv
module sop_pterm #(
  parameter int unsigned N_LIT = 58
) (
  input  logic [N_LIT-1:0] lits,
  input  logic [N_LIT-1:0] mask,
  output logic             term
);
  // an unconnected literal is forced to 1, so an empty mask yields TRUE
  always_comb begin
    term = &(lits | ~mask);
  end
endmodule

// File: rtl/sop_term_bank.sv
module sop_term_bank #(
  parameter int unsigned N_LIT  = 58,
  parameter int unsigned N_TERM = 16
) (
  input  logic [N_LIT-1:0]             lits,
  input  logic [N_TERM-1:0][N_LIT-1:0] masks,
  output logic [N_TERM-1:0]            terms
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    sop_pterm #(.N_LIT(N_LIT)) u_pt (
      .lits (lits),
      .mask (masks[t]),
      .term (terms[t])
    );
  end
endmodule

// File: rtl/sop_orsum.sv
module sop_orsum #(
  parameter int unsigned N_T = 4
) (
  input  logic [N_T-1:0] terms,
  output logic           sum
);
  always_comb begin
    sum = |terms;
  end
endmodule

// File: rtl/sop_plane.sv
module sop_plane
  import sop_pkg::*;
#(
  parameter  int unsigned N_IN     = DEF_N_IN,
  parameter  int unsigned N_OUT    = DEF_N_OUT,
  parameter  int unsigned N_SMALL  = DEF_N_SMALL,
  parameter  int unsigned SZ_SMALL = DEF_SZ_SMALL,
  parameter  int unsigned N_MID    = DEF_N_MID,
  parameter  int unsigned SZ_MID   = DEF_SZ_MID,
  parameter  int unsigned SZ_BIG   = DEF_SZ_BIG,
  localparam int unsigned N_LIT    = 2 * N_IN,
  localparam int unsigned N_LOGIC  =
    grp_base(N_OUT, N_SMALL, SZ_SMALL, N_MID, SZ_MID, SZ_BIG)
) (
  input  logic [N_IN-1:0]               arr_in,
  input  logic [N_LOGIC-1:0][N_LIT-1:0] logic_mask,
  input  logic [N_OUT-1:0][N_LIT-1:0]   oe_mask,
  input  logic [N_OUT-1:0][N_LIT-1:0]   ck_mask,
  input  logic [N_OUT-1:0][N_LIT-1:0]   set_mask,
  input  logic [N_OUT-1:0][N_LIT-1:0]   clr_mask,
  input  logic [N_LIT-1:0]              pload_mask,
  input  logic [N_LIT-1:0]              obs_mask,
  output logic [N_OUT-1:0]              sum_out,
  output logic [N_OUT-1:0]              oe_term,
  output logic [N_OUT-1:0]              ck_term,
  output logic [N_OUT-1:0]              set_term,
  output logic [N_OUT-1:0]              clr_term,
  output logic                          pload_term,
  output logic                          obs_term
);

  logic [N_LIT-1:0]   lits;
  logic [N_LOGIC-1:0] lterm;

  // literal pair per input: even = true, odd = complement
  always_comb begin
    for (int unsigned i = 0; i < N_IN; i++) begin
      lits[2*i]   = arr_in[i];
      lits[2*i+1] = ~arr_in[i];
    end
  end

  sop_term_bank #(.N_LIT(N_LIT), .N_TERM(N_LOGIC)) u_logic (
    .lits (lits), .masks (logic_mask), .terms (lterm)
  );
  sop_term_bank #(.N_LIT(N_LIT), .N_TERM(N_OUT)) u_oe (
    .lits (lits), .masks (oe_mask), .terms (oe_term)
  );
  sop_term_bank #(.N_LIT(N_LIT), .N_TERM(N_OUT)) u_ck (
    .lits (lits), .masks (ck_mask), .terms (ck_term)
  );
  sop_term_bank #(.N_LIT(N_LIT), .N_TERM(N_OUT)) u_set (
    .lits (lits), .masks (set_mask), .terms (set_term)
  );
  sop_term_bank #(.N_LIT(N_LIT), .N_TERM(N_OUT)) u_clr (
    .lits (lits), .masks (clr_mask), .terms (clr_term)
  );

  sop_pterm #(.N_LIT(N_LIT)) u_pload (
    .lits (lits), .mask (pload_mask), .term (pload_term)
  );
  sop_pterm #(.N_LIT(N_LIT)) u_obs (
    .lits (lits), .mask (obs_mask), .term (obs_term)
  );

  // one OR sum per output, width and offset fixed at elaboration
  for (genvar k = 0; k < N_OUT; k++) begin : g_sum
    localparam int unsigned NT   =
      grp_size(k, N_SMALL, SZ_SMALL, N_MID, SZ_MID, SZ_BIG);
    localparam int unsigned BASE =
      grp_base(k, N_SMALL, SZ_SMALL, N_MID, SZ_MID, SZ_BIG);
    sop_orsum #(.N_T(NT)) u_or (
      .terms (lterm[BASE +: NT]),
      .sum   (sum_out[k])
    );
  end

endmodule

// File: rtl/sop_plane_chk.sv
module sop_plane_chk
  import sop_pkg::*;
#(
  parameter  int unsigned N_IN     = DEF_N_IN,
  parameter  int unsigned N_OUT    = DEF_N_OUT,
  parameter  int unsigned N_SMALL  = DEF_N_SMALL,
  parameter  int unsigned SZ_SMALL = DEF_SZ_SMALL,
  parameter  int unsigned N_MID    = DEF_N_MID,
  parameter  int unsigned SZ_MID   = DEF_SZ_MID,
  parameter  int unsigned SZ_BIG   = DEF_SZ_BIG,
  localparam int unsigned N_LIT    = 2 * N_IN,
  localparam int unsigned N_LOGIC  =
    grp_base(N_OUT, N_SMALL, SZ_SMALL, N_MID, SZ_MID, SZ_BIG)
) (
  input logic [N_IN-1:0]               arr_in,
  input logic [N_LOGIC-1:0][N_LIT-1:0] logic_mask,
  input logic [N_OUT-1:0][N_LIT-1:0]   oe_mask,
  input logic [N_OUT-1:0][N_LIT-1:0]   ck_mask,
  input logic [N_OUT-1:0][N_LIT-1:0]   set_mask,
  input logic [N_OUT-1:0][N_LIT-1:0]   clr_mask,
  input logic [N_LIT-1:0]              pload_mask,
  input logic [N_LIT-1:0]              obs_mask,
  input logic [N_OUT-1:0]              sum_out,
  input logic [N_OUT-1:0]              oe_term,
  input logic [N_OUT-1:0]              ck_term,
  input logic [N_OUT-1:0]              set_term,
  input logic [N_OUT-1:0]              clr_term,
  input logic                          pload_term,
  input logic                          obs_term
);

  function automatic logic clash(input logic [N_LIT-1:0] m);
    for (int unsigned i = 0; i < N_IN; i++)
      if (m[2*i] && m[2*i+1]) return 1'b1;
    return 1'b0;
  endfunction

  always_comb begin
    if (pload_mask == '0) AST_PLOAD_EMPTY_TRUE: assert (pload_term); // R2
    if (obs_mask == '0) AST_OBS_EMPTY_TRUE: assert (obs_term); // R2
    if (clash(pload_mask)) AST_PLOAD_CLASH_FALSE: assert (!pload_term); // R3
    if (clash(obs_mask)) AST_OBS_CLASH_FALSE: assert (!obs_term); // R3
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_k
    localparam int unsigned NT   =
      grp_size(k, N_SMALL, SZ_SMALL, N_MID, SZ_MID, SZ_BIG);
    localparam int unsigned BASE =
      grp_base(k, N_SMALL, SZ_SMALL, N_MID, SZ_MID, SZ_BIG);
    logic any_open;
    logic all_shut;
    always_comb begin
      any_open = 1'b0;
      all_shut = 1'b1;
      for (int unsigned t = 0; t < NT; t++) begin
        if (logic_mask[BASE+t] == '0) any_open = 1'b1;
        if (!clash(logic_mask[BASE+t])) all_shut = 1'b0;
      end
      if (any_open) AST_SUM_OPEN_TERM_HIGH: assert (sum_out[k]); // R5
      if (all_shut) AST_SUM_ALL_CLASH_LOW: assert (!sum_out[k]); // R5
      if (clash(oe_mask[k])) AST_OE_CLASH_FALSE: assert (!oe_term[k]); // R6
      if (clash(ck_mask[k])) AST_CK_CLASH_FALSE: assert (!ck_term[k]); // R6
      if (set_mask[k] == '0) AST_SET_EMPTY_TRUE: assert (set_term[k]); // R6
      if (clr_mask[k] == '0) AST_CLR_EMPTY_TRUE: assert (clr_term[k]); // R6
    end
  end

endmodule

bind sop_plane sop_plane_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .N_SMALL(N_SMALL), .SZ_SMALL(SZ_SMALL),
  .N_MID(N_MID), .SZ_MID(SZ_MID), .SZ_BIG(SZ_BIG)
) chk_i (
  .arr_in(arr_in), .logic_mask(logic_mask), .oe_mask(oe_mask),
  .ck_mask(ck_mask), .set_mask(set_mask), .clr_mask(clr_mask),
  .pload_mask(pload_mask), .obs_mask(obs_mask), .sum_out(sum_out),
  .oe_term(oe_term), .ck_term(ck_term), .set_term(set_term),
  .clr_term(clr_term), .pload_term(pload_term), .obs_term(obs_term)
);

// File: tb/sop_plane_tb_top.sv
module sop_plane_tb_top;

  localparam int NI = 29;
  localparam int NL = 58;
  localparam int NO = 16;
  localparam int NT = 112;

  logic clk;
  logic rst_n;
  int   n_chk;
  int   n_err;
  int   cyc;
  bit   done;

  logic [NI-1:0]         arr_in;
  logic [NT-1:0][NL-1:0] logic_mask;
  logic [NO-1:0][NL-1:0] oe_mask, ck_mask, set_mask, clr_mask;
  logic [NL-1:0]         pload_mask, obs_mask;
  logic [NO-1:0]         sum_out, oe_term, ck_term, set_term, clr_term;
  logic                  pload_term, obs_term;

  sop_plane dut_i (
    .arr_in(arr_in), .logic_mask(logic_mask), .oe_mask(oe_mask),
    .ck_mask(ck_mask), .set_mask(set_mask), .clr_mask(clr_mask),
    .pload_mask(pload_mask), .obs_mask(obs_mask), .sum_out(sum_out),
    .oe_term(oe_term), .ck_term(ck_term), .set_term(set_term),
    .clr_term(clr_term), .pload_term(pload_term), .obs_term(obs_term)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference: a term fails if a connected literal is low
  function automatic bit m_term(input logic [NL-1:0] m, input logic [NI-1:0] x);
    for (int i = 0; i < NI; i++) begin
      if (m[2*i] && (x[i] == 1'b0)) return 1'b0;
      if (m[2*i+1] && (x[i] == 1'b1)) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [NO-1:0] m_sums(input logic [NT-1:0][NL-1:0] lm,
                                           input logic [NI-1:0] x);
    logic [NO-1:0] s;
    int idx;
    idx = 0;
    for (int k = 0; k < NO; k++) begin
      int n;
      n = (k < 8) ? 4 : ((k < 12) ? 8 : 12);
      s[k] = 1'b0;
      for (int t = 0; t < n; t++) begin
        s[k] = s[k] | m_term(lm[idx], x);
        idx++;
      end
    end
    return s;
  endfunction

  function automatic logic [NO-1:0] m_bank(input logic [NO-1:0][NL-1:0] mm,
                                           input logic [NI-1:0] x);
    logic [NO-1:0] r;
    for (int k = 0; k < NO; k++) r[k] = m_term(mm[k], x);
    return r;
  endfunction

  function automatic int owner(input int t);
    if (t < 32) return t / 4;
    if (t < 64) return 8 + (t - 32) / 8;
    return 12 + (t - 64) / 12;
  endfunction

  function automatic logic [NL-1:0] sparse();
    logic [NL-1:0] m;
    for (int j = 0; j < NL; j++) m[j] = (($urandom % 18) == 0);
    return m;
  endfunction

  task automatic chk(input string req, input logic [NO-1:0] got,
                     input logic [NO-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  localparam logic [NL-1:0] CLASH0 = 58'h3;

  initial begin
    n_chk = 0; n_err = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0;
    arr_in = '0; logic_mask = '0; oe_mask = '0; ck_mask = '0;
    set_mask = '0; clr_mask = '0; pload_mask = '0; obs_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: all masks empty -> every term and sum high
    for (int p = 0; p < 2; p++) begin
      arr_in = (p == 0) ? '0 : '1;
      #1;
      chk("R2 sums", sum_out, '1);
      chk("R2 oe", oe_term, '1);
      chk("R2 ck", ck_term, '1);
      chk("R2 set", set_term, '1);
      chk("R2 clr", clr_term, '1);
      chk("R2 global", {14'd0, pload_term, obs_term}, 16'h3);
      @(negedge clk);
    end

    // R3: both polarities of one input connected -> low regardless of inputs
    for (int i = 0; i < NI; i++) begin
      logic [NL-1:0] cm;
      cm = '0;
      cm[2*i] = 1'b1; cm[2*i+1] = 1'b1;
      for (int t = 0; t < NT; t++) logic_mask[t] = cm;
      for (int k = 0; k < NO; k++) begin
        oe_mask[k] = cm; ck_mask[k] = cm; set_mask[k] = cm; clr_mask[k] = cm;
      end
      pload_mask = cm; obs_mask = cm;
      arr_in = NI'($urandom);
      #1;
      chk("R3 sums", sum_out, '0);
      chk("R3 ctrl", oe_term | ck_term | set_term | clr_term, '0);
      chk("R3 global", {14'd0, pload_term, obs_term}, '0);
      @(negedge clk);
    end

    // R5: open one logic term at a time, all others clashed
    oe_mask = '0; ck_mask = '0; set_mask = '0; clr_mask = '0;
    pload_mask = '0; obs_mask = '0;
    for (int t = 0; t < NT; t++) logic_mask[t] = CLASH0;
    for (int t = 0; t < NT; t++) begin
      logic_mask[t] = '0;
      arr_in = NI'($urandom);
      #1;
      chk("R5 group owner", sum_out, NO'(1) << owner(t));
      logic_mask[t] = CLASH0;
      @(negedge clk);
    end
    // R6: control terms untouched by logic masks
    #1;
    chk("R6 ctrl independent of logic", oe_term & ck_term & set_term & clr_term, '1);
    @(negedge clk);

    // R1: single literal through preload term, both input values
    for (int j = 0; j < NL; j++) begin
      for (int v = 0; v < 2; v++) begin
        pload_mask = NL'(1) << j;
        arr_in = NI'($urandom);
        arr_in[j/2] = v[0];
        #1;
        chk("R1 literal polarity", {15'd0, pload_term},
            {15'd0, ((j % 2) == 0) ? v[0] : ~v[0]});
        @(negedge clk);
      end
    end

    // R4 R5 R6 R7: random sparse masks against the reference
    for (int n = 0; n < 300; n++) begin
      for (int t = 0; t < NT; t++) logic_mask[t] = sparse();
      for (int k = 0; k < NO; k++) begin
        oe_mask[k] = sparse(); ck_mask[k] = sparse();
        set_mask[k] = sparse(); clr_mask[k] = sparse();
      end
      pload_mask = sparse(); obs_mask = sparse();
      for (int q = 0; q < 4; q++) begin
        arr_in = NI'($urandom);
        #1;
        chk("R4 R5 sums", sum_out, m_sums(logic_mask, arr_in));
        chk("R6 oe", oe_term, m_bank(oe_mask, arr_in));
        chk("R6 ck", ck_term, m_bank(ck_mask, arr_in));
        chk("R6 set", set_term, m_bank(set_mask, arr_in));
        chk("R6 clr", clr_term, m_bank(clr_mask, arr_in));
        chk("R7 global", {14'd0, pload_term, obs_term},
            {14'd0, m_term(pload_mask, arr_in), m_term(obs_mask, arr_in)});
        @(negedge clk);
      end
    end

    finish_run();
  end

endmodule